// File: doc/BRIEF.md
# SPI Slave Data Path with FIFO Request Generation

This block is the slave-side data path of an SPI port. It holds a transmit FIFO, a receive FIFO and a one-word receive holding register between the serial assembler and the receive FIFO. It brings the serial pins into the system clock domain and moves one 8-bit word per frame in mode 0, MSB first. It also turns FIFO conditions into sticky status flags and request lines for the host: TX underflow, RX overflow and RX drain.

The host loads transmit words through a push port and takes received words through a pop port. It enables each request separately and chooses whether the drain request goes to an interrupt line or to a DMA request line. It clears flags by pulsing a clear strobe together with a bit mask. An overwrite control decides what happens to the word that arrives when all receive storage is already full.

Top module: `spi_slv_fifo_req`

## Requirements
- R1: When a frame starts (`ss_n` falls) with the TX FIFO empty, `flag_tx_uf` becomes 1 and `miso` sends 0 for all 8 bits of that frame.
- R2: `irq_tx_uf` is 1 exactly while `flag_tx_uf` and `en_tx_uf` are both 1.
- R3: The drain request is active while `rx_count` is nonzero and `en_rx_drain` is 1. It is inactive when the count is zero or the enable is 0.
- R4: When `drain_to_dma` is 1, the active drain request appears on `dma_rx_drain` only. When `drain_to_dma` is 0, it appears on `irq_rx_drain` only.
- R5: The receive FIFO holds 4 words and the holding register holds one more. If a frame starts while both are full, `flag_rx_of` becomes 1. Five buffered words never set it.
- R6: `irq_rx_of` is 1 exactly while `flag_rx_of` and `en_rx_of` are both 1.
- R7: For an overflowing frame, `rx_keep_new`=1 replaces the held word with the new word. `rx_keep_new`=0 discards the new word and keeps the held word. `rx_keep_new` is sampled when the frame starts.
- R8: `overrun` is the OR of `flag_tx_uf` and `flag_rx_of`.
- R9: Flags are sticky. A cycle with `clr_we`=1 clears `flag_tx_uf` when `clr_mask[0]`=1 and clears `flag_rx_of` when `clr_mask[1]`=1. A set and a clear in the same cycle leave the flag at 1.
- R10: In mode 0, with `mosi` sampled on the rising edge of `sck` and `miso` changed on the falling edge, a frame shifts the oldest TX FIFO word out MSB first. The frame delivers the received byte to `rx_data` in FIFO order.
- R11: After reset, all flags and request lines are 0, `rx_count` is 0, `tx_full` is 0 and `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the external master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| tx_push | input | 1 | Write one word into the TX FIFO |
| tx_data | input | 8 | Word to transmit |
| tx_full | output | 1 | TX FIFO is full |
| rx_pop | input | 1 | Remove the head word of the RX FIFO |
| rx_data | output | 8 | Head word of the RX FIFO |
| rx_count | output | 3 | Number of words in the RX FIFO |
| en_tx_uf | input | 1 | Underflow request enable |
| en_rx_of | input | 1 | Overflow request enable |
| en_rx_drain | input | 1 | Drain request enable |
| drain_to_dma | input | 1 | Drain routing: 1 to DMA, 0 to interrupt |
| rx_keep_new | input | 1 | Overflow policy: 1 keeps the new word |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 2 | Bit 0 clears underflow, bit 1 clears overflow |
| flag_tx_uf | output | 1 | Sticky TX underflow flag |
| flag_rx_of | output | 1 | Sticky RX overflow flag |
| irq_tx_uf | output | 1 | Underflow interrupt |
| irq_rx_of | output | 1 | Overflow interrupt |
| irq_rx_drain | output | 1 | Drain interrupt |
| dma_rx_drain | output | 1 | Drain DMA request |
| overrun | output | 1 | Either FIFO overrun flag is set |

## Verification
The assertions assume that the serial inputs change slowly compared with the system clock. Each level of `sck` and `ss_n` must last several clock cycles, so that every edge is seen once after synchronisation. They also assume that `mosi` is stable before the rising edge of `sck`. The stimulus holds each serial clock phase for six system cycles and changes `mosi` only while `sck` is low. It also keeps `ss_n` high for several cycles between frames, so that every frame start is detected as a separate event.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  localparam int CLR_UF_BIT = 0;
  localparam int CLR_OF_BIT = 1;

  // Overflow needs every receive storage stage occupied
  function automatic logic rx_overflow_hit(input logic fifo_full, input logic hold_full);
    return fifo_full && hold_full;
  endfunction

  // Drain condition before routing
  function automatic logic drain_active(input logic nonempty, input logic enable);
    return nonempty && enable;
  endfunction

  // {dma, irq}
  function automatic logic [1:0] route_drain(input logic req, input logic to_dma);
    return {req && to_dma, req && !to_dma};
  endfunction

  // Sticky flag update: set dominates clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set || (cur && !clr);
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_slv_fifo.sv
module spi_slv_fifo #(
  parameter int DW = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop, empty;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spi_slv_req.sv
module spi_slv_req
  import spi_slv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_uf,
  input  logic       set_of,
  input  logic       clr_we,
  input  logic [1:0] clr_mask,
  input  logic       en_uf,
  input  logic       en_of,
  input  logic       en_drain,
  input  logic       to_dma,
  input  logic       rx_nonempty,
  output logic       flag_uf,
  output logic       flag_of,
  output logic       irq_uf,
  output logic       irq_of,
  output logic       irq_drain,
  output logic       dma_drain,
  output logic       overrun
);

  logic [1:0] drain_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_uf <= 1'b0;
      flag_of <= 1'b0;
    end else begin
      flag_uf <= sticky_next(flag_uf, set_uf, clr_we && clr_mask[CLR_UF_BIT]);
      flag_of <= sticky_next(flag_of, set_of, clr_we && clr_mask[CLR_OF_BIT]);
    end
  end

  assign drain_vec = route_drain(drain_active(rx_nonempty, en_drain), to_dma);
  assign dma_drain = drain_vec[1];
  assign irq_drain = drain_vec[0];
  assign irq_uf    = flag_uf && en_uf;
  assign irq_of    = flag_of && en_of;
  assign overrun   = flag_uf || flag_of;

endmodule

// File: rtl/spi_slv_fifo_req.sv
module spi_slv_fifo_req
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic [CNT_W-1:0]  rx_count,
  input  logic              en_tx_uf,
  input  logic              en_rx_of,
  input  logic              en_rx_drain,
  input  logic              drain_to_dma,
  input  logic              rx_keep_new,
  input  logic              clr_we,
  input  logic [1:0]        clr_mask,
  output logic              flag_tx_uf,
  output logic              flag_rx_of,
  output logic              irq_tx_uf,
  output logic              irq_rx_of,
  output logic              irq_rx_drain,
  output logic              dma_rx_drain,
  output logic              overrun
);

  // synchronised pins: {sck, ss_n, mosi}
  logic [2:0] pins_s;
  logic       sck_s, ss_s, mosi_s, sck_q, ss_q;

  spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, ss_n, mosi}), .q(pins_s)
  );
  assign {sck_s, ss_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      ss_q  <= ss_s;
    end
  end

  // named internal events
  logic ev_frame_start, ev_sck_rise, ev_sck_fall, ev_frame_end;
  logic ev_underflow, ev_overflow;
  logic tx_empty, rx_full, hold_full, hold_push, accept;

  logic [DATA_W-1:0] tx_rdata, tx_sh, hold_word, word_in;
  logic [DATA_W-2:0] rx_asm;
  logic [BIT_W-1:0]  bit_cnt;
  logic              frame_done, drop_frame;
  logic [CNT_W-1:0]  tx_count;

  assign ev_frame_start = !ss_s && ss_q;
  assign ev_sck_rise    = !ss_s && sck_s && !sck_q;
  assign ev_sck_fall    = !ss_s && !sck_s && sck_q;
  assign tx_empty       = (tx_count == '0);
  assign ev_underflow   = ev_frame_start && tx_empty;
  assign ev_overflow    = ev_frame_start && rx_overflow_hit(rx_full, hold_full);
  assign word_in        = {rx_asm, mosi_s};
  assign ev_frame_end   = ev_sck_rise && !frame_done && (bit_cnt == BIT_W'(DATA_W - 1));
  assign accept         = ev_frame_end && !drop_frame;
  assign hold_push      = hold_full && !rx_full;

  // serial shifting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh      <= '0;
      rx_asm     <= '0;
      bit_cnt    <= '0;
      frame_done <= 1'b0;
      drop_frame <= 1'b0;
    end else if (ev_frame_start) begin
      tx_sh      <= tx_empty ? '0 : tx_rdata;
      bit_cnt    <= '0;
      frame_done <= 1'b0;
      drop_frame <= ev_overflow && !rx_keep_new;
    end else begin
      if (ev_sck_rise && !frame_done) begin
        rx_asm  <= word_in[DATA_W-2:0];
        bit_cnt <= bit_cnt + BIT_W'(1);
        if (ev_frame_end) frame_done <= 1'b1;
      end
      if (ev_sck_fall) tx_sh <= tx_sh << 1;
    end
  end

  // receive holding register ahead of the FIFO
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_word <= word_in;
      hold_full <= 1'b1;
    end else if (hold_push) begin
      hold_full <= 1'b0;
    end
  end

  assign miso = !ss_s && tx_sh[DATA_W-1];

  spi_slv_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
    .pop(ev_frame_start && !tx_empty), .rdata(tx_rdata),
    .count(tx_count), .full(tx_full)
  );

  spi_slv_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push(hold_push), .wdata(hold_word),
    .pop(rx_pop), .rdata(rx_data), .count(rx_count), .full(rx_full)
  );

  spi_slv_req u_req (
    .clk(clk), .rst_n(rst_n),
    .set_uf(ev_underflow), .set_of(ev_overflow),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .en_uf(en_tx_uf), .en_of(en_rx_of), .en_drain(en_rx_drain),
    .to_dma(drain_to_dma), .rx_nonempty(rx_count != '0),
    .flag_uf(flag_tx_uf), .flag_of(flag_rx_of),
    .irq_uf(irq_tx_uf), .irq_of(irq_rx_of),
    .irq_drain(irq_rx_drain), .dma_drain(dma_rx_drain),
    .overrun(overrun)
  );

endmodule

// File: rtl/spi_slv_fifo_req_chk.sv
module spi_slv_fifo_req_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_underflow,
  input logic             ev_overflow,
  input logic             miso,
  input logic             en_tx_uf,
  input logic             en_rx_of,
  input logic             drain_to_dma,
  input logic             clr_we,
  input logic [1:0]       clr_mask,
  input logic [CNT_W-1:0] rx_count,
  input logic             flag_tx_uf,
  input logic             flag_rx_of,
  input logic             irq_tx_uf,
  input logic             irq_rx_of,
  input logic             irq_rx_drain,
  input logic             dma_rx_drain,
  input logic             overrun
);

  // R1
  uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |=> flag_tx_uf);

  // R1
  uf_miso_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |=> !miso);

  // R2
  uf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_uf |-> (flag_tx_uf && en_tx_uf));

  // R3
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> !(irq_rx_drain || dma_rx_drain));

  // R4
  drain_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_to_dma ? !irq_rx_drain : !dma_rx_drain);

  // R5
  of_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> flag_rx_of);

  // R5
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(DEPTH));

  // R6
  of_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_of |-> (flag_rx_of && en_rx_of));

  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun == (flag_tx_uf || flag_rx_of));

  // R9
  of_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rx_of && !(clr_we && clr_mask[1])) |=> flag_rx_of);

  // R9
  uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_tx_uf && !(clr_we && clr_mask[0])) |=> flag_tx_uf);

endmodule

bind spi_slv_fifo_req spi_slv_fifo_req_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_underflow(ev_underflow), .ev_overflow(ev_overflow), .miso(miso),
  .en_tx_uf(en_tx_uf), .en_rx_of(en_rx_of), .drain_to_dma(drain_to_dma),
  .clr_we(clr_we), .clr_mask(clr_mask), .rx_count(rx_count),
  .flag_tx_uf(flag_tx_uf), .flag_rx_of(flag_rx_of),
  .irq_tx_uf(irq_tx_uf), .irq_rx_of(irq_rx_of),
  .irq_rx_drain(irq_rx_drain), .dma_rx_drain(dma_rx_drain),
  .overrun(overrun)
);

// File: tb/spi_slv_fifo_req_bench.sv
module spi_slv_fifo_req_bench;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso;
  logic       tx_push = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_full;
  logic       rx_pop = 1'b0;
  logic [7:0] rx_data;
  logic [2:0] rx_count;
  logic       en_tx_uf = 1'b0, en_rx_of = 1'b0, en_rx_drain = 1'b0;
  logic       drain_to_dma = 1'b0, rx_keep_new = 1'b0;
  logic       clr_we = 1'b0;
  logic [1:0] clr_mask = '0;
  logic       flag_tx_uf, flag_rx_of, irq_tx_uf, irq_rx_of;
  logic       irq_rx_drain, dma_rx_drain, overrun;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  spi_slv_fifo_req u_spi_slv_fifo_req (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_count(rx_count),
    .en_tx_uf(en_tx_uf), .en_rx_of(en_rx_of), .en_rx_drain(en_rx_drain),
    .drain_to_dma(drain_to_dma), .rx_keep_new(rx_keep_new),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .flag_tx_uf(flag_tx_uf), .flag_rx_of(flag_rx_of),
    .irq_tx_uf(irq_tx_uf), .irq_rx_of(irq_rx_of),
    .irq_rx_drain(irq_rx_drain), .dma_rx_drain(dma_rx_drain),
    .overrun(overrun)
  );

  // {tx word, mosi word}
  localparam logic [15:0] VEC [4] = '{16'hA53C, 16'h0FF0, 16'h8001, 16'h7E81};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] w);
    tx_push = 1'b1; tx_data = w; tick(1);
    tx_push = 1'b0; tick(1);
  endtask

  task automatic pop_check(input string tag, input logic [7:0] exp);
    check(tag, 32'(rx_data), 32'(exp));
    rx_pop = 1'b1; tick(1);
    rx_pop = 1'b0; tick(3);
  endtask

  task automatic clear(input logic [1:0] m);
    clr_we = 1'b1; clr_mask = m; tick(1);
    clr_we = 1'b0; clr_mask = '0; tick(1);
  endtask

  // one 8-bit mode-0 frame; collide pulses a clear of bit0 in the frame-start set cycle
  task automatic frame(input logic [7:0] mo, output logic [7:0] mi, input logic collide);
    mi = '0;
    ss_n = 1'b0;
    for (int t = 1; t <= HALF; t++) begin
      tick(1);
      if (t == 2 && collide) begin clr_we = 1'b1; clr_mask = 2'b01; end
      if (t == 3) begin clr_we = 1'b0; clr_mask = '0; end
    end
    for (int b = 7; b >= 0; b--) begin
      mosi = mo[b];
      tick(HALF);
      mi = {mi[6:0], miso};
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    ss_n = 1'b1;
    tick(2 * HALF);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] mi;
    tick(5);
    rst_n = 1'b1;
    tick(2);

    // R11 reset state
    check("R11 flags", 32'({flag_tx_uf, flag_rx_of}), 32'd0);
    check("R11 requests", 32'({irq_tx_uf, irq_rx_of, irq_rx_drain, dma_rx_drain, overrun}), 32'd0);
    check("R11 rx_count", 32'(rx_count), 32'd0);
    check("R11 tx_full/miso", 32'({tx_full, miso}), 32'd0);

    // R10 table of frames
    for (int i = 0; i < 4; i++) begin
      push_tx(VEC[i][15:8]);
      frame(VEC[i][7:0], mi, 1'b0);
      check("R10 miso word", 32'(mi), 32'(VEC[i][15:8]));
      check("R10 rx_count", 32'(rx_count), 32'd1);
      pop_check("R10 rx word", VEC[i][7:0]);
      check("R1 no underflow", 32'(flag_tx_uf), 32'd0);
    end

    // R3 / R4 drain request and routing
    push_tx(8'h00);
    frame(8'h5A, mi, 1'b0);
    en_rx_drain = 1'b0; tick(1);
    check("R3 disabled", 32'({irq_rx_drain, dma_rx_drain}), 32'd0);
    en_rx_drain = 1'b1; drain_to_dma = 1'b0; tick(1);
    check("R4 to irq", 32'({irq_rx_drain, dma_rx_drain}), 32'b10);
    drain_to_dma = 1'b1; tick(1);
    check("R4 to dma", 32'({irq_rx_drain, dma_rx_drain}), 32'b01);
    pop_check("R10 drain word", 8'h5A);
    check("R3 empty", 32'({irq_rx_drain, dma_rx_drain}), 32'd0);

    // R1 / R2 / R8 underflow
    frame(8'h33, mi, 1'b0);
    check("R1 miso zeros", 32'(mi), 32'd0);
    check("R1 flag", 32'(flag_tx_uf), 32'd1);
    check("R8 overrun", 32'(overrun), 32'd1);
    check("R2 irq off", 32'(irq_tx_uf), 32'd0);
    en_tx_uf = 1'b1; tick(1);
    check("R2 irq on", 32'(irq_tx_uf), 32'd1);
    pop_check("R10 underflow frame rx", 8'h33);

    // R9 clear, then set-vs-clear collision
    clear(2'b10);
    check("R9 other bit kept", 32'(flag_tx_uf), 32'd1);
    clear(2'b01);
    check("R9 cleared", 32'({flag_tx_uf, overrun, irq_tx_uf}), 32'd0);
    frame(8'h44, mi, 1'b0);
    frame(8'h45, mi, 1'b1);
    check("R9 set wins", 32'(flag_tx_uf), 32'd1);
    pop_check("R10 rx 44", 8'h44);
    pop_check("R10 rx 45", 8'h45);
    clear(2'b11);

    // R5 / R6 / R7 overflow, discard policy
    rx_keep_new = 1'b0;
    for (int k = 0; k < 5; k++) frame(8'h11 + 8'(k), mi, 1'b0);
    check("R5 five words no flag", 32'(flag_rx_of), 32'd0);
    check("R5 fifo full", 32'(rx_count), 32'd4);
    frame(8'h66, mi, 1'b0);
    check("R5 overflow flag", 32'(flag_rx_of), 32'd1);
    check("R6 irq off", 32'(irq_rx_of), 32'd0);
    en_rx_of = 1'b1; tick(1);
    check("R6 irq on", 32'(irq_rx_of), 32'd1);
    for (int k = 0; k < 5; k++) pop_check("R7 drop order", 8'h11 + 8'(k));
    check("R7 drop empty", 32'(rx_count), 32'd0);
    clear(2'b10);
    check("R9 of cleared", 32'({flag_rx_of, irq_rx_of}), 32'd0);

    // R7 keep-new policy
    rx_keep_new = 1'b1;
    for (int k = 0; k < 5; k++) frame(8'h21 + 8'(k), mi, 1'b0);
    frame(8'h77, mi, 1'b0);
    check("R5 overflow again", 32'(flag_rx_of), 32'd1);
    for (int k = 0; k < 4; k++) pop_check("R7 keep order", 8'h21 + 8'(k));
    pop_check("R7 keep replaced", 8'h77);
    check("R7 keep empty", 32'(rx_count), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule